// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped periodic timer. It divides the system clock by sixteen and uses the result to step a period counter. Software programs the counter's terminal value. Each time the counter passes that value it returns to zero. At the same moment a 12-bit tally of completed periods goes up by one, a status flag sets, and, if enabled, a level interrupt rises.

Software rebuilds a free-running time base from the tally and the in-period count, which both appear in a single value word. The block offers two views of that word. Reading one view acknowledges: it hands back the word, then clears the tally and the status flag. Reading the other view leaves all state unchanged. Clearing the timer enable does not stop the counter at once. The counter runs on until it next reaches zero and then halts, so software can poll the value until it reads zero before restarting cleanly.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register word index 0 is the mode register: period value in bits 19:0, timer enable in bit 24, interrupt enable in bit 25. It reads back exactly these fields and returns zero in every other bit. Index 1 is status (bit 0 = period completed), index 2 is the acknowledging value view and index 3 is the side-effect-free value view. Only index 0 is writable.
- R3: While running, the in-period count steps once every 16 clocks. When the timer is started from the stopped state, the first step lands 16 clocks after the edge that writes the enable.
- R4: A step taken while the count is at or above the period value returns the count to zero, adds one to the completed-period tally and sets status bit 0. A period therefore lasts (value + 1) steps.
- R5: A read of index 2 returns the tally in bits 31:20 and the in-period count in bits 19:0. After that read, the tally and status bit 0 are zero.
- R6: A read of index 3 returns the same fields as index 2 and changes neither the tally nor the status bit.
- R7: The completed-period tally saturates at 4095.
- R8: If a period completes on the same edge as an acknowledging read, the tally afterwards is 1 and status bit 0 stays set.
- R9: When the timer enable is cleared, counting continues until the in-period count returns to zero and then stops. The tally keeps the period completed by that final wrap. A later restart begins from a fresh prescaler phase.
- R10: `irq_o` is high while status bit 0 and the interrupt enable are both set. It stays high as a level until an acknowledging read or a mode write removes it.
- R11: With the timer enabled and the interrupt enable clear, periods are still counted and flagged, but `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe; side effects apply on the clock edge |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Period interrupt, level |

## Verification
The assertions assume that a read or write strobe is held for exactly one clock per access. They also assume the read and write strobes are never both high in the same cycle, so each acknowledging read clears the tally only once. The bench drives every access from a task that raises a single strobe for one cycle. It observes timing without side effects by changing the address with both strobes low, so the combinational read data can be sampled at any chosen cycle. Before each scenario the bench disables the timer, polls until the count is zero and acknowledges. This fixes the prescaler phase, so wrap and acknowledge cycles can be predicted exactly.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned EN_BIT  = 24;
  localparam int unsigned IEN_BIT = 25;
  localparam int unsigned DATA_W  = 32;

  typedef enum logic [1:0] {
    REG_MODE     = 2'd0,
    REG_STATUS   = 2'd1,
    REG_VAL_ACK  = 2'd2,
    REG_VAL_PEEK = 2'd3
  } pit_reg_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PS_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = run_i;
    end else begin : g_div
      logic [PS_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        cnt_q <= '0;
        else if (!run_i)                    cnt_q <= '0;  // fresh phase on restart
        else if (cnt_q == PS_W'(DIV - 1))   cnt_q <= '0;
        else                                cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == PS_W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pit_period_ctr.sv
module pit_period_ctr #(
  parameter int unsigned PIV_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PIV_W-1:0] period_i,
  output logic [PIV_W-1:0] cur_o,
  output logic             run_o,
  output logic             wrap_o
);
  logic [PIV_W-1:0] cur_q;

  // keeps running after disable until count is back at zero
  assign run_o  = en_i || (cur_q != '0);
  assign wrap_o = tick_i && (cur_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (tick_i)  cur_q <= wrap_o ? '0 : cur_q + 1'b1;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/pit_ovf_ctr.sv
module pit_ovf_ctr #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             status_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else if (ack_i) begin
      // a period finishing on the ack edge survives the clear
      cnt_q    <= wrap_i ? CNT_W'(1) : '0;
      status_q <= wrap_i;
    end else if (wrap_i) begin
      status_q <= 1'b1;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign status_o = status_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned PIV_W = 20,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DIV   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int unsigned CNT_LSB = DATA_W - CNT_W;

  logic [PIV_W-1:0] piv_q;
  logic             en_q, ien_q;
  logic             mode_wr, ack;
  logic             tick, run, wrap, status;
  logic [PIV_W-1:0] cur;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      mode_word, value_word;
  logic             unused_wdata;

  assign mode_wr      = wr_i && (addr_i == REG_MODE);
  assign ack          = rd_i && (addr_i == REG_VAL_ACK);
  assign unused_wdata = ^{wdata_i[31:IEN_BIT+1], wdata_i[EN_BIT-1:PIV_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      piv_q <= '0;
      en_q  <= 1'b0;
      ien_q <= 1'b0;
    end else if (mode_wr) begin
      piv_q <= wdata_i[PIV_W-1:0];
      en_q  <= wdata_i[EN_BIT];
      ien_q <= wdata_i[IEN_BIT];
    end
  end

  pit_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  pit_period_ctr #(.PIV_W(PIV_W)) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .en_i     (en_q),
    .period_i (piv_q),
    .cur_o    (cur),
    .run_o    (run),
    .wrap_o   (wrap)
  );

  pit_ovf_ctr #(.CNT_W(CNT_W)) u_ovf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .ack_i    (ack),
    .cnt_o    (cnt),
    .status_o (status)
  );

  always_comb begin
    mode_word              = '0;
    mode_word[PIV_W-1:0]   = piv_q;
    mode_word[EN_BIT]      = en_q;
    mode_word[IEN_BIT]     = ien_q;
    value_word             = '0;
    value_word[PIV_W-1:0]  = cur;
    value_word[31:CNT_LSB] = cnt;
  end

  always_comb begin
    unique case (pit_reg_e'(addr_i))
      REG_MODE:   rdata_o = mode_word;
      REG_STATUS: rdata_o = {31'd0, status};
      default:    rdata_o = value_word;
    endcase
  end

  assign irq_o = status && ien_q;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned PIV_W = 20,
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_i,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic             irq_o,
  input logic             tick,
  input logic             wrap,
  input logic [PIV_W-1:0] cur,
  input logic [CNT_W-1:0] cnt,
  input logic             status,
  input logic             en
);
  logic ack_rd, peek_rd, mode_wr;
  assign ack_rd  = rd_i && addr_i == 2'd2;
  assign peek_rd = rd_i && addr_i == 2'd3;
  assign mode_wr = wr_i && addr_i == 2'd0;

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
  assert_cur_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cur));
  assert_wrap_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (status && cur == '0));
  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !wrap) |=> (!status && cnt == '0));
  assert_peek_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peek_rd && !wrap) |=> ($stable(cnt) && $stable(status)));
  assert_cnt_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt) && !ack_rd) |=> (&cnt));
  assert_ack_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && wrap) |=> (status && cnt == CNT_W'(1)));
  assert_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && cur == '0) |=> cur == '0);
  assert_irq_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(ack_rd || mode_wr));
endmodule

bind pit_timer pit_timer_chk #(.PIV_W(PIV_W), .CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .irq_o  (irq_o),
  .tick   (tick),
  .wrap   (wrap),
  .cur    (cur),
  .cnt    (cnt),
  .status (status),
  .en     (en_q)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, fails = 0, cyc = 0, t0 = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(logic [1:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic look(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_k(int k);
    while (cyc < t0 + k) @(negedge clk);
  endtask

  task automatic halt();
    logic [31:0] v;
    do_write(2'd0, 32'd0);
    look(2'd3, v);
    while (v[19:0] != 0) begin
      @(negedge clk);
      look(2'd3, v);
    end
    do_read(2'd2, v);
    @(negedge clk);
  endtask

  task automatic start(logic [19:0] piv, bit ien);
    do_write(2'd0, {6'd0, ien, 1'b1, 4'd0, piv});
    t0 = cyc;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      look(a[1:0], v);
      check("R1 reg zero", v, 32'd0);
    end
    check("R1 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    do_write(2'd0, 32'hFEF0_0005);
    look(2'd0, v);
    check("R2 mode readback", v, 32'h0200_0005);
    do_write(2'd1, 32'hFFFF_FFFF);
    look(2'd1, v);
    check("R2 status not writable", v, 32'd0);
    do_write(2'd0, 32'd0);
  endtask

  task automatic t_period_peek_ack();
    logic [31:0] v, v2;
    halt();
    start(20'd2, 1'b0);
    wait_k(15); look(2'd3, v); check("R3 no step before 16", v, 32'd0);
    wait_k(16); look(2'd3, v); check("R3 first step at 16", v, 32'd1);
    wait_k(47); look(2'd3, v); check("R4 before wrap", v, 32'd2);
    wait_k(48); look(2'd3, v); check("R4 wrap value", v, 32'h0010_0000);
    look(2'd1, v); check("R4 status set", v, 32'd1);
    check("R11 irq stays low", {31'd0, irq}, 32'd0);
    do_read(2'd3, v); do_read(2'd3, v2);
    check("R6 peek value", v, 32'h0010_0000);
    check("R6 peek repeat", v2, 32'h0010_0000);
    look(2'd1, v); check("R6 status kept", v, 32'd1);
    do_read(2'd2, v);
    check("R5 ack value", v, 32'h0010_0000);
    look(2'd3, v); check("R5 tally cleared", v, 32'd0);
    look(2'd1, v); check("R5 status cleared", v, 32'd0);
  endtask

  task automatic t_multi();
    logic [31:0] v;
    halt();
    start(20'd0, 1'b0);
    wait_k(80); look(2'd3, v); check("R4 five periods", v, 32'h0050_0000);
  endtask

  task automatic t_coincide();
    logic [31:0] v;
    halt();
    start(20'd0, 1'b0);
    wait_k(31);
    do_read(2'd2, v); check("R8 ack returns one", v, 32'h0010_0000);
    look(2'd3, v); check("R8 tally after coincident ack", v, 32'h0010_0000);
    look(2'd1, v); check("R8 status kept", v, 32'd1);
    wait_k(40);
    do_read(2'd2, v);
    look(2'd3, v); check("R5 plain ack clears", v, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    halt();
    start(20'd0, 1'b1);
    wait_k(15); check("R10 irq low before wrap", {31'd0, irq}, 32'd0);
    wait_k(16); check("R10 irq high on wrap", {31'd0, irq}, 32'd1);
    wait_k(20); check("R10 irq level held", {31'd0, irq}, 32'd1);
    do_read(2'd2, v);
    check("R10 irq cleared by ack", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    halt();
    start(20'd9, 1'b0);
    wait_k(80); look(2'd3, v); check("R9 running", v, 32'd5);
    do_write(2'd0, 32'd9);
    wait_k(100); look(2'd3, v); check("R9 runs on after disable", v, 32'd6);
    wait_k(159); look(2'd3, v); check("R9 last step", v, 32'd9);
    wait_k(160); look(2'd3, v); check("R9 final wrap", v, 32'h0010_0000);
    wait_k(400); look(2'd3, v); check("R9 stays stopped", v, 32'h0010_0000);
    do_read(2'd2, v);
    start(20'd9, 1'b0);
    wait_k(15); look(2'd3, v); check("R9 fresh phase 15", v, 32'd0);
    wait_k(16); look(2'd3, v); check("R9 fresh phase 16", v, 32'd1);
  endtask

  task automatic t_sat();
    logic [31:0] v;
    halt();
    start(20'd0, 1'b0);
    wait_k(4100 * 16);
    look(2'd3, v); check("R7 saturated", v, 32'hFFF0_0000);
    do_read(2'd2, v); check("R7 ack saturated", v[31:20], 32'hFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_period_peek_ack();
    t_multi();
    t_coincide();
    t_irq();
    t_stop();
    t_sat();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule